// File: doc/BRIEF.md
# Burst Receive Deframer

This block sits behind a demodulator that hands it one hard-decided line bit at a time, qualified by a valid strobe. While no frame is open it watches the NRZI-decoded bit stream for the pattern that opens a burst: an alternating training run followed by the flag octet. Once that pattern is found it opens a frame. From then on it decodes each bit, strips the inserted zero bits and runs the frame check sequence over the result. Destuffed octets leave on a byte-wide port, marked as the first and the last of a frame.

When the next flag arrives, or the frame overruns its length budget, the block ends the frame. It sorts the outcome into a 3-bit channel state code and raises a one-cycle alert. A good frame closes with an end-of-frame marker on its last payload byte. A failed frame is abandoned without that marker, and the block goes back to hunting. A synchronous state-reset input drops any open frame and returns the channel to Idle.

Top module: `burst_deframer`

## Requirements
- R1: After `rst_n` is released, `chan_state` is 0 (Idle), and both `out_vld` and `state_alert` are low.
- R2: The line is NRZI decoded: an unchanged line level between two valid bits gives a decoded 1, and a change gives a decoded 0.
- R3: `chan_state` becomes 1 (Receiving) only after a start pattern on the decoded bits. That pattern is the eight bits 0,1,1,1,1,1,1,0 (the flag 0x7E), preceded by 24 training bits that alternate in either phase. The 4 oldest training bits are not examined. No bytes are output while the channel is not Receiving.
- R4: While Receiving, a decoded 0 that follows five decoded 1s in a row is deleted. A sixth decoded 1 in a row marks the end flag. The 0,1,1,1,1,1 that precede it are not frame data.
- R5: Frame data is gathered into bytes least significant bit first. Every byte except the last two (the check sequence) appears on `out_byte` with `out_vld` high. The first such byte has `out_sof` high.
- R6: At the end flag, if the destuffed length is a whole number of bytes, at least 3 bytes long, and the check sequence is correct, the frame is good. The check is CRC-16 with polynomial 0x1021, preset 0xFFFF, bits processed LSB first, with the complemented value sent low byte first. On a good frame the last payload byte is output with `out_eof` high and `chan_state` returns to 0.
- R7: A frame that ends on a byte boundary with a wrong check sequence, or with fewer than 3 bytes, sets `chan_state` to 3 and gets no `out_eof`.
- R8: A frame whose end flag comes when the destuffed bit count is not a multiple of 8 sets `chan_state` to 4. This test takes priority over the R7 test.
- R9: A frame of 172 destuffed bytes (check sequence included) is accepted. When byte 173 completes, the frame ends at once with `chan_state` 2 and no `out_eof`, and hunting resumes.
- R10: Every frame end raises `state_alert` for exactly one cycle, in the cycle in which `chan_state` takes its new code.
- R11: An error code (2, 3 or 4) is held until the next start pattern moves the channel to Receiving, or until a state reset.
- R12: A one-cycle `state_rst` forces `chan_state` to 0 with no alert and no `out_eof`. Any open frame is dropped and hunting restarts.
- R13: Cycles with `rx_bit_vld` low are ignored, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| state_rst | input | 1 | Synchronous channel state reset, one cycle |
| rx_bit | input | 1 | Hard-decided line bit |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` |
| out_byte | output | 8 | Destuffed payload byte |
| out_vld | output | 1 | `out_byte` valid |
| out_sof | output | 1 | First payload byte of the frame |
| out_eof | output | 1 | Last payload byte of a good frame |
| chan_state | output | 3 | 0 Idle, 1 Receiving, 2 too long, 3 check mismatch, 4 misaligned end |
| state_alert | output | 1 | One-cycle pulse at every frame end |

## Verification
The embedded properties assume three things about the inputs. `state_rst` is a single-cycle pulse. Two frame ends are always separated by a full start pattern. The start pattern is never imitated inside payload bits that the block hunts through after an abandoned frame. The stimulus meets these conditions in the following way:
- Every frame is built by a bench encoder that inserts a stuffing zero after any five ones.
- Frames are separated by runs of decoded ones.
- The state reset is pulsed for exactly one cycle.

Random payloads, random idle gaps and a random training phase exercise the bit paths. The corrupted leading training bits stay inside the window that the start detector does not examine.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

  typedef enum logic [2:0] {
    CH_IDLE      = 3'd0,
    CH_RECV      = 3'd1,
    CH_ERR_LONG  = 3'd2,
    CH_ERR_FCS   = 3'd3,
    CH_ERR_ALIGN = 3'd4
  } chan_st_e;

  localparam logic [7:0]  FLAG_PAT     = 8'b0111_1110;
  localparam logic [15:0] FCS_POLY_REV = 16'h8408;
  localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE  = 16'hF0B8;

endpackage

// File: rtl/bfd_rst_sync.sv
module bfd_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/bfd_nrzi_dec.sv
module bfd_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic line_bit,
  input  logic line_vld,
  output logic dec_bit,
  output logic dec_vld
);

  logic lvl_q;
  logic lvl_d;

  // Line level of the previous valid bit; held across invalid cycles.
  always_comb begin
    lvl_d = lvl_q;
    if (line_vld) begin
      lvl_d = line_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  // No transition decodes to 1, a transition to 0.
  assign dec_bit = ~(line_bit ^ lvl_q);
  assign dec_vld = line_vld;

  AST_NRZI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |=> $stable(lvl_q)); // R13

endmodule

// File: rtl/bfd_hunt.sv
module bfd_hunt
  import bfd_pkg::*;
#(
  parameter int PRE_BITS  = 24,
  parameter int SKIP_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic dec_bit,
  input  logic dec_vld,
  output logic start_hit
);

  localparam int SR_W  = PRE_BITS + 8;
  localparam int N_CHK = PRE_BITS - SKIP_BITS - 1;

  logic [SR_W-1:0]  sr_q;
  logic [SR_W-1:0]  sr_d;
  logic [N_CHK-1:0] alt;

  // Newest decoded bit enters at bit 0.
  always_comb begin
    sr_d = sr_q;
    if (clr) begin
      sr_d = '0;
    end else if (dec_vld) begin
      sr_d = {sr_q[SR_W-2:0], dec_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  // Neighbouring training bits must differ, except in the oldest SKIP_BITS.
  for (genvar g = 0; g < N_CHK; g++) begin : g_alt
    assign alt[g] = sr_d[8+g] ^ sr_d[9+g];
  end

  assign start_hit = arm & dec_vld & ~clr & (sr_d[7:0] == FLAG_PAT) & (&alt);

endmodule

// File: rtl/bfd_frame.sv
module bfd_frame
  import bfd_pkg::*;
#(
  parameter int MAX_BYTES = 172,
  parameter int RUN_LEN   = 5,
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       dec_bit,
  input  logic       dec_vld,
  output logic [7:0] out_byte,
  output logic       out_vld,
  output logic       out_sof,
  output logic       out_eof,
  output logic       end_evt,
  output chan_st_e   end_code
);

  localparam int PIPE_LEN = RUN_LEN + 1;
  localparam int ONES_W   = $clog2(RUN_LEN + 1);
  localparam int PF_W     = $clog2(PIPE_LEN + 1);
  localparam int HOLD     = FCS_BYTES + 1;
  localparam int HF_W     = $clog2(HOLD + 1);
  localparam int LEN_W    = $clog2(MAX_BYTES + 1);

  logic [ONES_W-1:0]   ones_q,  ones_d;
  logic [PIPE_LEN-1:0] pipe_q,  pipe_d;
  logic [PF_W-1:0]     pfill_q, pfill_d;
  logic [7:0]          asm_q,   asm_d;
  logic [2:0]          bcnt_q,  bcnt_d;
  logic [LEN_W-1:0]    nbyt_q,  nbyt_d;
  logic [15:0]         crc_q,   crc_d;
  logic [HOLD*8-1:0]   hold_q,  hold_d;
  logic [HF_W-1:0]     hfill_q, hfill_d;
  logic                sent_q,  sent_d;
  logic [7:0]          obyte_q, obyte_d;
  logic                ovld_q,  ovld_d;
  logic                osof_q,  osof_d;
  logic                oeof_q,  oeof_d;
  logic                step;
  logic                clear_all;
  logic                fb;

  assign step = en & dec_vld & ~clr;
  assign fb   = crc_q[0] ^ pipe_q[0];

  always_comb begin
    ones_d    = ones_q;
    pipe_d    = pipe_q;
    pfill_d   = pfill_q;
    asm_d     = asm_q;
    bcnt_d    = bcnt_q;
    nbyt_d    = nbyt_q;
    crc_d     = crc_q;
    hold_d    = hold_q;
    hfill_d   = hfill_q;
    sent_d    = sent_q;
    obyte_d   = obyte_q;
    ovld_d    = 1'b0;
    osof_d    = 1'b0;
    oeof_d    = 1'b0;
    end_evt   = 1'b0;
    end_code  = CH_IDLE;
    clear_all = clr;
    if (step) begin
      if (ones_q == ONES_W'(RUN_LEN) && dec_bit) begin
        // End flag: the run of ones exceeded the stuffing limit.
        end_evt   = 1'b1;
        clear_all = 1'b1;
        if (bcnt_q != 3'd0) begin
          end_code = CH_ERR_ALIGN;
        end else if (nbyt_q < LEN_W'(HOLD) || crc_q != FCS_RESIDUE) begin
          end_code = CH_ERR_FCS;
        end else begin
          end_code = CH_IDLE;
          obyte_d  = hold_q[HOLD*8-1 -: 8];
          ovld_d   = 1'b1;
          osof_d   = ~sent_q;
          oeof_d   = 1'b1;
        end
      end else if (ones_q == ONES_W'(RUN_LEN)) begin
        // Inserted zero: dropped.
        ones_d = '0;
      end else begin
        ones_d = dec_bit ? ones_q + ONES_W'(1) : '0;
        pipe_d = {dec_bit, pipe_q[PIPE_LEN-1:1]};
        if (pfill_q != PF_W'(PIPE_LEN)) begin
          pfill_d = pfill_q + PF_W'(1);
        end else begin
          // Oldest bit leaves the flag look-behind window as frame data.
          crc_d  = {1'b0, crc_q[15:1]} ^ (fb ? FCS_POLY_REV : 16'h0000);
          asm_d  = {pipe_q[0], asm_q[7:1]};
          bcnt_d = bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            if (nbyt_q == LEN_W'(MAX_BYTES)) begin
              end_evt   = 1'b1;
              end_code  = CH_ERR_LONG;
              clear_all = 1'b1;
            end else begin
              nbyt_d = nbyt_q + LEN_W'(1);
              hold_d = {hold_q[(HOLD-1)*8-1:0], asm_d};
              if (hfill_q == HF_W'(HOLD)) begin
                obyte_d = hold_q[HOLD*8-1 -: 8];
                ovld_d  = 1'b1;
                osof_d  = ~sent_q;
                sent_d  = 1'b1;
              end else begin
                hfill_d = hfill_q + HF_W'(1);
              end
            end
          end
        end
      end
    end
    if (clear_all) begin
      ones_d  = '0;
      pfill_d = '0;
      bcnt_d  = 3'd0;
      nbyt_d  = '0;
      crc_d   = FCS_PRESET;
      hfill_d = '0;
      sent_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      pipe_q  <= '0;
      pfill_q <= '0;
      asm_q   <= 8'h00;
      bcnt_q  <= 3'd0;
      nbyt_q  <= '0;
      crc_q   <= FCS_PRESET;
      hold_q  <= '0;
      hfill_q <= '0;
      sent_q  <= 1'b0;
      obyte_q <= 8'h00;
      ovld_q  <= 1'b0;
      osof_q  <= 1'b0;
      oeof_q  <= 1'b0;
    end else begin
      ones_q  <= ones_d;
      pipe_q  <= pipe_d;
      pfill_q <= pfill_d;
      asm_q   <= asm_d;
      bcnt_q  <= bcnt_d;
      nbyt_q  <= nbyt_d;
      crc_q   <= crc_d;
      hold_q  <= hold_d;
      hfill_q <= hfill_d;
      sent_q  <= sent_d;
      obyte_q <= obyte_d;
      ovld_q  <= ovld_d;
      osof_q  <= osof_d;
      oeof_q  <= oeof_d;
    end
  end

  assign out_byte = obyte_q;
  assign out_vld  = ovld_q;
  assign out_sof  = osof_q;
  assign out_eof  = oeof_q;

  AST_ONES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(RUN_LEN)); // R4
  AST_PIPE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    pfill_q <= PF_W'(PIPE_LEN)); // R4
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nbyt_q <= LEN_W'(MAX_BYTES)); // R9
  AST_EOF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_vld); // R6
  AST_QUIET_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_vld); // R3

endmodule

// File: rtl/burst_deframer.sv
module burst_deframer
  import bfd_pkg::*;
#(
  parameter int MAX_BYTES = 172,
  parameter int PRE_BITS  = 24,
  parameter int SKIP_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       state_rst,
  input  logic       rx_bit,
  input  logic       rx_bit_vld,
  output logic [7:0] out_byte,
  output logic       out_vld,
  output logic       out_sof,
  output logic       out_eof,
  output logic [2:0] chan_state,
  output logic       state_alert
);

  logic     rst_q_n;
  logic     dec_bit;
  logic     dec_vld;
  logic     start_hit;
  logic     end_evt;
  chan_st_e end_code;
  chan_st_e st_q, st_d;
  logic     alert_q, alert_d;
  logic     recv;

  assign recv = (st_q == CH_RECV);

  bfd_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  bfd_nrzi_dec u_nrzi (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .line_bit (rx_bit),
    .line_vld (rx_bit_vld),
    .dec_bit  (dec_bit),
    .dec_vld  (dec_vld)
  );

  bfd_hunt #(
    .PRE_BITS  (PRE_BITS),
    .SKIP_BITS (SKIP_BITS)
  ) u_hunt (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr       (state_rst),
    .arm       (~recv),
    .dec_bit   (dec_bit),
    .dec_vld   (dec_vld),
    .start_hit (start_hit)
  );

  bfd_frame #(
    .MAX_BYTES (MAX_BYTES)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (state_rst),
    .en       (recv),
    .dec_bit  (dec_bit),
    .dec_vld  (dec_vld),
    .out_byte (out_byte),
    .out_vld  (out_vld),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .end_evt  (end_evt),
    .end_code (end_code)
  );

  always_comb begin
    st_d    = st_q;
    alert_d = 1'b0;
    if (state_rst) begin
      st_d = CH_IDLE;
    end else if (end_evt) begin
      st_d    = end_code;
      alert_d = 1'b1;
    end else if (start_hit) begin
      st_d = CH_RECV;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= CH_IDLE;
      alert_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      alert_q <= alert_d;
    end
  end

  assign chan_state  = st_q;
  assign state_alert = alert_q;

  AST_ALERT_NOT_RECV: assert property (@(posedge clk) disable iff (!rst_q_n)
    state_alert |-> (chan_state != CH_RECV)); // R10
  AST_ALERT_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    state_alert |=> !state_alert); // R10
  AST_EOF_GOOD: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_eof |-> (chan_state == CH_IDLE && state_alert)); // R6
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    state_rst |=> (chan_state == CH_IDLE && !state_alert && !out_vld)); // R12
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chan_state inside {CH_ERR_LONG, CH_ERR_FCS, CH_ERR_ALIGN} && !state_rst && !start_hit)
      |=> $stable(chan_state)); // R11
  AST_RECV_ENTRY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (chan_state == CH_RECV && $past(chan_state) != CH_RECV) |-> $past(rx_bit_vld)); // R3
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    chan_state <= 3'd4); // R7

endmodule

// File: tb/sim_burst_deframer.sv
module sim_burst_deframer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       state_rst = 1'b0;
  logic       rx_bit = 1'b0;
  logic       rx_bit_vld = 1'b0;
  logic [7:0] out_byte;
  logic       out_vld;
  logic       out_sof;
  logic       out_eof;
  logic [2:0] chan_state;
  logic       state_alert;

  always #4 clk = ~clk;

  burst_deframer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_rst   (state_rst),
    .rx_bit      (rx_bit),
    .rx_bit_vld  (rx_bit_vld),
    .out_byte    (out_byte),
    .out_vld     (out_vld),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .chan_state  (chan_state),
    .state_alert (state_alert)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic mon_on = 1'b0;
  logic line_lv = 1'b0;

  logic [7:0] pay[$];
  logic [7:0] got[$];
  bit         fq[$];
  int n_sof, n_eof, sof_at, eof_at, n_alert, alert_code;
  bit seen_recv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        got.push_back(out_byte);
        if (out_sof) begin n_sof++; sof_at = got.size() - 1; end
        if (out_eof) begin n_eof++; eof_at = got.size() - 1; end
      end
      if (state_alert) begin n_alert++; alert_code = int'(chan_state); end
      if (chan_state == 3'd1) seen_recv = 1'b1;
    end
  end

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c;
    bit f;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        f = c[0] ^ pay[i][k];
        c = c >> 1;
        if (f) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  // One decoded bit on the line; R13: random invalid cycles carry junk.
  task automatic tx_dec(input bit d);
    if (($urandom % 5) == 0) begin
      rx_bit_vld = 1'b0;
      rx_bit = 1'($urandom % 2);
      @(posedge clk); #1;
    end
    if (!d) line_lv = ~line_lv;   // R2: zero toggles the line
    rx_bit = line_lv;
    rx_bit_vld = 1'b1;
    @(posedge clk); #1;
    rx_bit_vld = 1'b0;
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) tx_dec(1'b1);
  endtask

  task automatic push_flag();
    fq.push_back(1'b0);
    for (int i = 0; i < 6; i++) fq.push_back(1'b1);
    fq.push_back(1'b0);
  endtask

  // Builds preamble, start flag, stuffed data, end flag into fq.
  task automatic build(input int extra_zeros, input bit corrupt);
    logic [7:0] dat[$];
    logic [15:0] f;
    bit ph, b;
    int ones;
    fq.delete();
    ph = 1'($urandom % 2);
    for (int i = 0; i < 24; i++) begin
      b = ((i % 2) == 0) ^ ph;
      if (i < 4) b = 1'($urandom % 2);
      fq.push_back(b);
    end
    push_flag();
    f = fcs_of(pay.size());
    dat = pay;
    dat.push_back(f[7:0]);
    dat.push_back(f[15:8]);
    if (corrupt) dat[0][3] = ~dat[0][3];
    ones = 0;
    foreach (dat[i]) begin
      for (int k = 0; k < 8; k++) begin
        fq.push_back(dat[i][k]);
        ones = dat[i][k] ? ones + 1 : 0;
        if (ones == 5) begin fq.push_back(1'b0); ones = 0; end
      end
    end
    for (int i = 0; i < extra_zeros; i++) fq.push_back(1'b0);
    push_flag();
  endtask

  task automatic clear_mon();
    got.delete();
    n_sof = 0; n_eof = 0; sof_at = -1; eof_at = -1;
    n_alert = 0; alert_code = -1; seen_recv = 1'b0;
  endtask

  task automatic run_frame(input int extra_zeros, input bit corrupt, input int exp_code, input string req);
    int mism;
    clear_mon();
    line_lv = 1'($urandom % 2);
    build(extra_zeros, corrupt);
    foreach (fq[i]) tx_dec(fq[i]);
    filler(20);
    chk(seen_recv, "R3 entered Receiving", int'(seen_recv), 1);
    chk(n_alert == 1, "R10 alert count", n_alert, 1);
    chk(alert_code == exp_code, req, alert_code, exp_code);
    chk(int'(chan_state) == exp_code, "R11 code held", int'(chan_state), exp_code);
    if (exp_code == 0) begin
      mism = 0;
      if (got.size() == pay.size()) begin
        foreach (pay[i]) if (got[i] !== pay[i]) mism++;
      end
      chk(got.size() == pay.size(), "R5 byte count", got.size(), pay.size());
      chk(mism == 0, "R4 R5 byte values", mism, 0);
      chk(n_sof == 1 && sof_at == 0, "R5 sof on first", sof_at, 0);
      chk(n_eof == 1 && eof_at == pay.size() - 1, "R6 eof on last", eof_at, pay.size() - 1);
    end else begin
      chk(n_eof == 0, "R7 R8 R9 no eof on error", n_eof, 0);
    end
  endtask

  task automatic rand_pay(input int n);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(8'($urandom));
  endtask

  initial begin
    int sd;
    int kind;
    int half;
    sd = $urandom(32'h0000_5A17);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(chan_state == 3'd0, "R1 reset state", int'(chan_state), 0);
    chk(!out_vld && !state_alert, "R1 outputs quiet", int'(out_vld), 0);
    @(posedge clk); #1;
    mon_on = 1'b1;
    filler(16);

    // Directed corner cases.
    rand_pay(1);   run_frame(0, 1'b0, 0, "R6 one byte good");
    pay.delete();  run_frame(0, 1'b0, 3, "R7 too short");
    pay = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
                   run_frame(0, 1'b0, 0, "R4 stuffing");
    rand_pay(6);   run_frame(0, 1'b1, 3, "R7 check mismatch");
    rand_pay(6);   run_frame(3, 1'b1, 4, "R8 align before crc");
    rand_pay(170); run_frame(0, 1'b0, 0, "R9 172 bytes accepted");
    rand_pay(171); run_frame(0, 1'b0, 2, "R9 173 bytes too long");

    // R12: state reset in the middle of a frame.
    clear_mon();
    rand_pay(10);
    build(0, 1'b0);
    half = 32 + 40;
    for (int i = 0; i < half; i++) tx_dec(fq[i]);
    @(posedge clk); #1 state_rst = 1'b1;
    @(posedge clk); #1 state_rst = 1'b0;
    @(negedge clk);
    chk(chan_state == 3'd0, "R12 idle after state reset", int'(chan_state), 0);
    @(posedge clk); #1;
    for (int i = half; i < fq.size(); i++) tx_dec(fq[i]);
    filler(20);
    chk(n_alert == 0, "R12 no alert", n_alert, 0);
    chk(n_eof == 0, "R12 no eof", n_eof, 0);
    chk(chan_state == 3'd0, "R12 stays idle", int'(chan_state), 0);
    rand_pay(4);   run_frame(0, 1'b0, 0, "R6 good after state reset");

    // Random mix.
    for (int r = 0; r < 18; r++) begin
      rand_pay(1 + int'($urandom % 24));
      kind = int'($urandom % 5);
      if (kind == 3)      run_frame(0, 1'b1, 3, "R7 random mismatch");
      else if (kind == 4) run_frame(1 + int'($urandom % 7), 1'b0, 4, "R8 random misaligned");
      else                run_frame(0, 1'b0, 0, "R6 random good");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule